// File: doc/BRIEF.md
# Flash converter digital back-end

This block is the digital tail of a flash analog-to-digital converter. A comparator array presents a vector of `2**DATA_W - 1` bits in which the asserted bits mark the reference levels lying below the analog input. The block registers that vector, reduces it to a `DATA_W`-bit code and presents the code on a held output bus. A two-phase conversion clock moves the data along.

The rising edge of the conversion clock captures the vector and moves the last encoded result toward the output. The falling edge encodes the captured vector and loads the output register. The result for a sample therefore appears while the sample two conversions later is being captured.

The code falls as the input rises: the highest input gives zero. Two active-low static controls select the output format. One control flips the most significant bit and the other flips the remaining bits. These selections give straight binary, offset two's complement, and the inverted form of each. The controls are registered together with each sample, so a format change follows the same pipeline as the data it applies to.

Top module: `fadc_backend`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0x00. Reset is asynchronous.
- R2: A vector captured at a rising edge of `clk_i` reaches `data_o` at the second falling edge after that capture. It stays on `data_o` through the rising edge that captures the vector two samples later.
- R3: With both controls high (true binary), `data_o` equals `2**DATA_W - 1` minus the number of asserted bits in the captured vector.
- R4: An all-ones vector (input above range) gives 0x00 in true binary. An all-zeros vector (input below range) gives 0xFF.
- R5: With `n_msb_inv_i` low and `n_lsb_inv_i` high, bit 7 of the true-binary code is inverted and bits 6:0 are unchanged. This is offset two's complement.
- R6: With `n_lsb_inv_i` low and `n_msb_inv_i` high, bits 6:0 of the true-binary code are inverted and bit 7 is unchanged.
- R7: With both controls low, all eight bits of the true-binary code are inverted.
- R8: The format controls are captured on the same rising edge as the vector. A change to the controls applies only to samples captured after the change, so results already in the pipeline keep their own format.
- R9: A vector with gaps (not a clean thermometer) is encoded from its count of asserted bits, with no correction applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock. Rising edge captures, falling edge encodes and loads the output. |
| rst_ni | input | 1 | Asynchronous reset, active low. |
| therm_i | input | 2**DATA_W-1 | Comparator vector. A set bit marks a level below the input. |
| n_lsb_inv_i | input | 1 | Active low. Inverts the lower DATA_W-1 output bits. |
| n_msb_inv_i | input | 1 | Active low. Inverts the top output bit. |
| data_o | output | DATA_W | Converted code. |

## Verification
The bench builds the block with the default `DATA_W` of 8, which gives a 255-bit comparator vector. At that width it can sweep every count from 0 to 255 under each of the four formats. The vectors are applied back to back, one per conversion cycle, so each comparison also pins down the two-sample latency. Because the format changes from vector to vector in the table, the bench shows that a format follows its own sample through the pipeline. Directed steps cover both saturation ends, a vector with gaps, and a reset asserted in the middle of a stream.

// File: rtl/fadc_pkg.sv
package fadc_pkg;
  // active-low format selects, carried alongside each sample
  typedef struct packed {
    logic n_msb;
    logic n_lsb;
  } fmt_t;

  localparam fmt_t FMT_CLEAR = '{n_msb: 1'b0, n_lsb: 1'b0};
endpackage

// File: rtl/fadc_capture.sv
module fadc_capture
  import fadc_pkg::*;
#(
  parameter int unsigned NTH = 255
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NTH-1:0] therm_i,
  input  fmt_t           fmt_i,
  output logic [NTH-1:0] therm_o,
  output fmt_t           fmt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_o <= '0;
      fmt_o   <= FMT_CLEAR;
    end else begin
      therm_o <= therm_i;
      fmt_o   <= fmt_i;
    end
  end
endmodule

// File: rtl/fadc_encoder.sv
module fadc_encoder #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NTH   = (1 << DATA_W) - 1
) (
  input  logic [NTH-1:0]    therm_i,
  output logic [DATA_W-1:0] code_o
);
  localparam logic [DATA_W-1:0] MAX_CODE = {DATA_W{1'b1}};

  logic [DATA_W-1:0] ones_cnt;

  // count of set bits; gaps are counted, not corrected
  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < int'(NTH); i++) begin
      ones_cnt = ones_cnt + DATA_W'(therm_i[i]);
    end
  end

  assign code_o = MAX_CODE - ones_cnt;

  always_comb begin
    // R4
    if (&therm_i) sat_top_chk: assert (code_o == '0);
    // R4
    if (therm_i == '0) sat_bot_chk: assert (code_o == MAX_CODE);
  end
endmodule

// File: rtl/fadc_out.sv
module fadc_out
  import fadc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_code_i,
  input  fmt_t              enc_fmt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] hold_code_q;
  fmt_t              hold_fmt_q;
  logic [DATA_W-1:0] inv_mask;

  // rising edge: move encoded result into staging
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_code_q <= '0;
      hold_fmt_q  <= FMT_CLEAR;
    end else begin
      hold_code_q <= enc_code_i;
      hold_fmt_q  <= enc_fmt_i;
    end
  end

  assign inv_mask = {~hold_fmt_q.n_msb, {(DATA_W-1){~hold_fmt_q.n_lsb}}};

  // falling edge: load output with format applied
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= hold_code_q ^ inv_mask;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_clear_chk: assert (data_o == '0);
  end

  // R3
  true_fmt_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (hold_fmt_q.n_msb && hold_fmt_q.n_lsb) |=> (data_o == $past(hold_code_q)));
  // R5
  msb_inv_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!hold_fmt_q.n_msb && hold_fmt_q.n_lsb) |=>
      (data_o[DATA_W-1] != $past(hold_code_q[DATA_W-1])) &&
      (data_o[DATA_W-2:0] == $past(hold_code_q[DATA_W-2:0])));
  // R6
  lsb_inv_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (hold_fmt_q.n_msb && !hold_fmt_q.n_lsb) |=>
      (data_o[DATA_W-1] == $past(hold_code_q[DATA_W-1])) &&
      (data_o[DATA_W-2:0] == ~$past(hold_code_q[DATA_W-2:0])));
  // R7
  all_inv_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!hold_fmt_q.n_msb && !hold_fmt_q.n_lsb) |=> (data_o == ~$past(hold_code_q)));
endmodule

// File: rtl/fadc_backend.sv
module fadc_backend
  import fadc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NTH   = (1 << DATA_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NTH-1:0]    therm_i,
  input  logic              n_lsb_inv_i,
  input  logic              n_msb_inv_i,
  output logic [DATA_W-1:0] data_o
);
  fmt_t              fmt_in;
  logic [NTH-1:0]    therm_q;
  fmt_t              cap_fmt_q;
  logic [DATA_W-1:0] code_d;
  logic [DATA_W-1:0] enc_code_q;
  fmt_t              enc_fmt_q;

  assign fmt_in = '{n_msb: n_msb_inv_i, n_lsb: n_lsb_inv_i};

  fadc_capture #(.NTH(NTH)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .therm_i (therm_i),
    .fmt_i   (fmt_in),
    .therm_o (therm_q),
    .fmt_o   (cap_fmt_q)
  );

  fadc_encoder #(.DATA_W(DATA_W)) u_encoder (
    .therm_i (therm_q),
    .code_o  (code_d)
  );

  // falling edge: register encoded sample
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_code_q <= '0;
      enc_fmt_q  <= FMT_CLEAR;
    end else begin
      enc_code_q <= code_d;
      enc_fmt_q  <= cap_fmt_q;
    end
  end

  fadc_out #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enc_code_i (enc_code_q),
    .enc_fmt_i  (enc_fmt_q),
    .data_o     (data_o)
  );
endmodule

// File: tb/fadc_backend_tb_top.sv
module fadc_backend_tb_top;
  localparam int unsigned W   = 8;
  localparam int unsigned NTH = (1 << W) - 1;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 16;

  // entry: {ones count[7:0], n_lsb_inv, n_msb_inv}
  localparam logic [9:0] VEC_TBL [NVEC] = '{
    {8'd0,   1'b1, 1'b1}, {8'd255, 1'b1, 1'b1}, {8'd1,   1'b1, 1'b1},
    {8'd254, 1'b1, 1'b1}, {8'd127, 1'b1, 1'b0}, {8'd128, 1'b1, 1'b0},
    {8'd129, 1'b0, 1'b1}, {8'd0,   1'b0, 1'b1}, {8'd255, 1'b0, 1'b0},
    {8'd127, 1'b0, 1'b0}, {8'd128, 1'b1, 1'b1}, {8'd64,  1'b1, 1'b0},
    {8'd200, 1'b0, 1'b1}, {8'd3,   1'b0, 1'b0}, {8'd250, 1'b1, 1'b0},
    {8'd100, 1'b1, 1'b1}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NTH-1:0] therm_i = '0;
  logic           n_lsb_inv_i = 1'b1;
  logic           n_msb_inv_i = 1'b1;
  logic [W-1:0]   data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [W-1:0] exp_q [2];
  bit           vld_q [2] = '{1'b0, 1'b0};
  string        req_q [2];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fadc_backend #(.DATA_W(W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .therm_i     (therm_i),
    .n_lsb_inv_i (n_lsb_inv_i),
    .n_msb_inv_i (n_msb_inv_i),
    .data_o      (data_o)
  );

  function automatic logic [NTH-1:0] mk_therm(int k);
    logic [NTH-1:0] v;
    for (int i = 0; i < int'(NTH); i++) v[i] = (i < k);
    return v;
  endfunction

  function automatic logic [W-1:0] model(int ones, logic nl, logic nm);
    logic [W-1:0] c;
    c = W'(int'(NTH) - ones);
    if (!nm) c[W-1] = ~c[W-1];
    if (!nl) c[W-2:0] = ~c[W-2:0];
    return c;
  endfunction

  function automatic string fmt_req(logic nl, logic nm);
    if (nl && nm)  return "R3";
    if (nl && !nm) return "R5";
    if (!nl && nm) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one conversion cycle: check the result of two samples back, then drive
  task automatic step(logic [NTH-1:0] v, int ones, logic nl, logic nm,
                      string req, bit chk);
    @(negedge clk_i);
    #1;
    if (vld_q[1]) check(req_q[1], data_o, exp_q[1]);
    exp_q[1] = exp_q[0]; vld_q[1] = vld_q[0]; req_q[1] = req_q[0];
    exp_q[0] = model(ones, nl, nm); vld_q[0] = chk; req_q[0] = req;
    therm_i = v;
    n_lsb_inv_i = nl;
    n_msb_inv_i = nm;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL R2: watchdog expired, actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NTH-1:0] bub;
    repeat (3) @(negedge clk_i);
    #1;
    check("R1", data_o, 8'h00);
    rst_ni = 1'b1;

    // table: format changes every sample (R2 R8)
    for (int i = 0; i < int'(NVEC); i++) begin
      logic [9:0] e;
      e = VEC_TBL[i];
      step(mk_therm(int'(e[9:2])), int'(e[9:2]), e[1], e[0],
           {fmt_req(e[1], e[0]), " R2 R8"}, 1'b1);
    end

    // full sweep under each format
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k <= int'(NTH); k++) begin
        logic nl, nm;
        nl = f[1]; nm = f[0];
        step(mk_therm(k), k, nl, nm,
             ((k == 0 || k == int'(NTH)) && nl && nm) ? "R4" : fmt_req(nl, nm),
             1'b1);
      end
    end

    // R4 saturation ends, true binary
    step('1, int'(NTH), 1'b1, 1'b1, "R4", 1'b1);
    step('0, 0, 1'b1, 1'b1, "R4", 1'b1);

    // R9 vector with gaps: bits 0..99 minus bit 50, plus bit 120 -> 100 ones
    bub = mk_therm(100);
    bub[50] = 1'b0;
    bub[120] = 1'b1;
    step(bub, 100, 1'b1, 1'b1, "R9", 1'b1);
    step(bub, 100, 1'b0, 1'b1, "R9", 1'b1);

    // flush
    step('0, 0, 1'b1, 1'b1, "", 1'b0);
    step('0, 0, 1'b1, 1'b1, "", 1'b0);
    @(negedge clk_i);
    #1;
    if (vld_q[1]) check(req_q[1], data_o, exp_q[1]);

    // R1 reset mid-stream clears output at once
    therm_i = mk_therm(5);
    repeat (3) @(negedge clk_i);
    #1;
    check("R2", data_o, 8'd250);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1", data_o, 8'h00);
    repeat (2) @(posedge clk_i);
    #1;
    check("R1", data_o, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule